// File: doc/BRIEF.md
# I2S Master Transmit Serializer

This block turns a stream of 32-bit words, read from a show-ahead FIFO, into a two-channel I2S bitstream. It is the bus master: it derives the bit clock and the word select from its own master clock, and it drives both of them. Each FIFO word carries one channel sample in its low bits. Words are taken in pairs: the first goes to the left slot and the second to the right slot.

Software-side configuration reaches the block as three plain inputs: a transmit enable, an 8-bit clock ratio and a 6-bit sample resolution. The bit clock period is 2×(ratio+2) master-clock cycles. The resolution sets both the slot length and how many low bits of each word are sent. After each enable the block sends one all-zero frame before it reads any queued data. When the FIFO is empty at a slot start, that slot is filled with zeros and the clocks keep running. When the enable is cleared, the block finishes the current frame and then parks every output low.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset, and whenever the block is idle, `bit_clk`, `word_sel` and `ser_data` are low and `fifo_rd_en` is low.
- R2: While running, `bit_clk` is high for ratio+2 master-clock cycles and low for ratio+2 cycles, a period of 2×(ratio+2).
- R3: Each slot lasts W bit clocks and carries bits W-1 down to 0 of its word, MSB first; bits at W and above are never sent. W is the resolution input clamped to the range 2 to 32.
- R4: `word_sel` is 0 for the left slot and 1 for the right slot, and it changes one bit clock before the MSB of each slot (during the last bit of the previous slot).
- R5: Each enable starts with one full frame of zeros, beginning with the left slot. No word is popped during that frame.
- R6: Outside the zero frame, the block pops exactly one word at the start of each slot, left then right, and only when `fifo_empty` is low. The pop is a single-cycle `fifo_rd_en` pulse in the master-clock cycle before `bit_clk` falls.
- R7: If `fifo_empty` is high at a slot start, that slot is sent as zeros and the bit clock does not stall.
- R8: When `tx_en` is low at the end of a frame, the block stops at that frame boundary, having sent whole frames only. All outputs are then low.
- R9: Ratio and resolution are captured at enable and at every frame boundary. A change made mid-frame takes effect from the next frame.
- R10: `word_sel` and `ser_data` change only at the master-clock edge where `bit_clk` falls, so the receiver can sample them on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| ratio | input | 8 | Clock ratio; half bit-clock period is ratio+2 cycles |
| resolution | input | 6 | Sample width in bits (clamped to 2..32) |
| fifo_empty | input | 1 | FIFO has no word to offer |
| fifo_data | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_rd_en | output | 1 | Pops the head word |
| bit_clk | output | 1 | I2S bit clock |
| word_sel | output | 1 | I2S word select (0 = left) |
| ser_data | output | 1 | I2S serial data |

## Verification
The block behaves as follows after enable:
- The outputs show the first bit at the enable edge.
- `bit_clk` first rises ratio+2 cycles after the enable edge.
- Each new bit, and any change of `word_sel`, appears at the edge where `bit_clk` falls.
- A pop is seen in the cycle just before that edge.
- A stop takes effect at the falling edge that closes the frame.

The bench checks each of these where it is due:
- It samples `ser_data` and `word_sel` on the falling master-clock edge that follows each rise of `bit_clk`, which is halfway through each bit.
- It measures bit-clock period and high time from the cycles between those rises and falls.
- It compares the captured bit sequence with one it builds from the requirements.
- After clearing the enable, it waits a fixed window longer than a whole frame before counting the bits and checking for idle.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
    // Sequencer operating mode
    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_RUN  = 1'b1
    } tx_mode_e;

    // Shortest slot that keeps the word-select lead of one bit meaningful
    localparam int MIN_SLOT_BITS = 2;
endpackage

// File: rtl/i2s_bclk_div.sv
`timescale 1ns/1ps
module i2s_bclk_div #(
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              sck,
    output logic              fall_evt
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              sck;
    } div_state_t;

    div_state_t q, d;
    logic       wrap;

    always_comb begin
        d    = q;
        wrap = (q.cnt == half - HALF_W'(1));
        if (!run) begin
            d.cnt = '0;
            d.sck = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.sck = ~q.sck;
        end else begin
            d.cnt = q.cnt + HALF_W'(1);
        end
        fall_evt = run && q.sck && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck = q.sck;
endmodule

// File: rtl/i2s_frame_seq.sv
`timescale 1ns/1ps
module i2s_frame_seq
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int RATIO_W = 8,
    parameter int RES_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic [RATIO_W-1:0]   ratio,
    input  logic [RES_W-1:0]     resolution,
    input  logic                 fifo_empty,
    input  logic [WORD_W-1:0]    fifo_data,
    input  logic                 fall_evt,
    output logic                 fifo_rd_en,
    output logic                 run,
    output logic [RATIO_W:0]     half,
    output logic                 ws,
    output logic                 sd
);
    localparam int POS_W  = $clog2(2 * WORD_W);
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int WID_W  = $clog2(WORD_W + 1);
    localparam int HALF_W = RATIO_W + 1;
    localparam int CW     = POS_W + 2;

    typedef struct packed {
        tx_mode_e            mode;
        logic                zero_frame;
        logic [WID_W-1:0]    width;
        logic [HALF_W-1:0]   half;
        logic [POS_W-1:0]    pos;
        logic [IDX_W-1:0]    idx;
        logic [WORD_W-1:0]   word;
        logic                ws;
        logic                sd;
    } seq_state_t;

    seq_state_t q, d;

    logic [WID_W-1:0]  w_new;
    logic [HALF_W-1:0] half_new;
    logic [CW-1:0]     flen;
    logic [CW-1:0]     np;
    logic              take;

    function automatic logic [WID_W-1:0] clamp_width(input logic [RES_W-1:0] r);
        if (int'(r) < MIN_SLOT_BITS) return WID_W'(MIN_SLOT_BITS);
        else if (int'(r) > WORD_W)   return WID_W'(WORD_W);
        else                         return WID_W'(r);
    endfunction

    always_comb begin
        d        = q;
        take     = 1'b0;
        w_new    = clamp_width(resolution);
        half_new = HALF_W'(ratio) + HALF_W'(2);
        flen     = CW'(q.width) + CW'(q.width);
        np       = CW'(q.pos) + CW'(1);
        case (q.mode)
            MODE_IDLE: begin
                d.ws = 1'b0;
                d.sd = 1'b0;
                if (tx_en) begin
                    d.mode       = MODE_RUN;
                    d.zero_frame = 1'b1;
                    d.width      = w_new;
                    d.half       = half_new;
                    d.pos        = '0;
                    d.idx        = IDX_W'(w_new - WID_W'(1));
                    d.word       = '0;
                end
            end
            default: begin
                if (fall_evt) begin
                    if (np == flen) begin
                        // frame boundary
                        if (!tx_en) begin
                            d.mode = MODE_IDLE;
                            d.pos  = '0;
                            d.ws   = 1'b0;
                            d.sd   = 1'b0;
                        end else begin
                            take         = !fifo_empty;
                            d.zero_frame = 1'b0;
                            d.width      = w_new;
                            d.half       = half_new;
                            d.pos        = '0;
                            d.idx        = IDX_W'(w_new - WID_W'(1));
                            d.word       = take ? fifo_data : '0;
                            d.sd         = d.word[d.idx];
                            d.ws         = 1'b0;
                        end
                    end else begin
                        d.pos = POS_W'(np);
                        if (np == CW'(q.width)) begin
                            // right slot starts
                            take   = !fifo_empty && !q.zero_frame;
                            d.idx  = IDX_W'(q.width - WID_W'(1));
                            d.word = take ? fifo_data : '0;
                        end else begin
                            d.idx = q.idx - IDX_W'(1);
                        end
                        d.sd = d.word[d.idx];
                        d.ws = ((np + CW'(1)) >= CW'(q.width)) && ((np + CW'(1)) < flen);
                    end
                end
            end
        endcase
        fifo_rd_en = take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run  = (q.mode == MODE_RUN);
    assign half = q.half;
    assign ws   = q.ws;
    assign sd   = q.sd;
endmodule

// File: rtl/i2s_tx_serializer.sv
`timescale 1ns/1ps
module i2s_tx_serializer #(
    parameter int WORD_W  = 32,
    parameter int RATIO_W = 8,
    parameter int RES_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RES_W-1:0]   resolution,
    input  logic               fifo_empty,
    input  logic [WORD_W-1:0]  fifo_data,
    output logic               fifo_rd_en,
    output logic               bit_clk,
    output logic               word_sel,
    output logic               ser_data
);
    localparam int HALF_W = RATIO_W + 1;

    logic              run;
    logic              fall_evt;
    logic [HALF_W-1:0] half;

    i2s_bclk_div #(.HALF_W(HALF_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half     (half),
        .sck      (bit_clk),
        .fall_evt (fall_evt)
    );

    i2s_frame_seq #(
        .WORD_W  (WORD_W),
        .RATIO_W (RATIO_W),
        .RES_W   (RES_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .ratio      (ratio),
        .resolution (resolution),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fall_evt   (fall_evt),
        .fifo_rd_en (fifo_rd_en),
        .run        (run),
        .half       (half),
        .ws         (word_sel),
        .sd         (ser_data)
    );
endmodule

// File: rtl/i2s_tx_checker.sv
`timescale 1ns/1ps
module i2s_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic bit_clk,
    input logic word_sel,
    input logic ser_data,
    input logic fifo_rd_en,
    input logic fifo_empty
);
    // R1 / R8: idle means every output parked low
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!bit_clk && !word_sel && !ser_data && !fifo_rd_en));

    // R2: bit clock only toggles while running
    assert_clk_when_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clk |-> run);

    // R6: pop only when data is offered
    assert_pop_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> !fifo_empty);

    // R6: pop sits in the high phase just before bit_clk falls
    assert_pop_before_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> bit_clk ##1 !bit_clk);

    // R10: word select moves only with a falling bit clock
    assert_ws_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_sel != $past(word_sel)) |-> (!bit_clk && $past(bit_clk)));

    // R10: data moves only with a falling bit clock
    assert_sd_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_data != $past(ser_data)) |-> (!bit_clk && $past(bit_clk)));
endmodule

bind i2s_tx_serializer i2s_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .bit_clk    (bit_clk),
    .word_sel   (word_sel),
    .ser_data   (ser_data),
    .fifo_rd_en (fifo_rd_en),
    .fifo_empty (fifo_empty)
);

// File: tb/test_i2s_tx_serializer.sv
`timescale 1ns/1ps
module test_i2s_tx_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int STOP_WAIT  = 800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic [7:0]  ratio = 8'd0;
    logic [5:0]  resolution = 6'd16;
    logic        fifo_empty;
    logic [31:0] fifo_data;
    logic        fifo_rd_en;
    logic        bit_clk, word_sel, ser_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_tx_serializer i_i2s_tx_serializer (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ratio(ratio),
        .resolution(resolution), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd_en(fifo_rd_en), .bit_clk(bit_clk), .word_sel(word_sel),
        .ser_data(ser_data)
    );

    // bench FIFO (show-ahead)
    logic [31:0] fmem [0:15];
    int f_wr = 0;
    int f_rd = 0;
    assign fifo_empty = (f_rd == f_wr);
    assign fifo_data  = fmem[f_rd % 16];
    always @(posedge clk) if (rst_n && fifo_rd_en) f_rd <= f_rd + 1;

    // receiver monitor
    logic cap_ws [0:4095];
    logic cap_sd [0:4095];
    int   cap_n = 0;
    int   cyc = 0;
    int   last_rise = -1;
    int   period = 0;
    int   high_len = 0;
    logic sck_prev = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (bit_clk && !sck_prev) begin
            cap_ws[cap_n] = word_sel;
            cap_sd[cap_n] = ser_data;
            cap_n++;
            if (last_rise >= 0) period = cyc - last_rise;
            last_rise = cyc;
        end
        if (!bit_clk && sck_prev) high_len = cyc - last_rise;
        sck_prev = bit_clk;
    end

    // expected stream
    logic exp_ws [0:4095];
    logic exp_sd [0:4095];
    int   exp_n = 0;
    int   cap_base = 0;
    int   checks = 0;
    int   fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        fmem[f_wr % 16] = w;
        f_wr++;
    endtask

    task automatic add_frame(input int w, input logic [31:0] l, input logic [31:0] r);
        for (int p = 0; p < 2*w; p++) begin
            exp_ws[exp_n] = ((p + 1) >= w) && ((p + 1) < 2*w);
            exp_sd[exp_n] = (p < w) ? l[w-1-p] : r[2*w-1-p];
            exp_n++;
        end
    endtask

    task automatic begin_run(input logic [7:0] rt, input logic [5:0] rs);
        @(negedge clk);
        exp_n = 0;
        cap_base = cap_n;
        last_rise = -1;
        ratio = rt;
        resolution = rs;
        tx_en = 1'b1;
    endtask

    task automatic wait_bits(input int n);
        for (int i = 0; i < 20000 && (cap_n - cap_base) < n; i++) @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk);
        tx_en = 1'b0;
        repeat (STOP_WAIT) @(negedge clk);
    endtask

    task automatic compare_run(input string req);
        int got = cap_n - cap_base;
        int bad = 0;
        int first = -1;
        check(got == exp_n, req, "bit count", got, exp_n);
        for (int i = 0; i < exp_n && i < got; i++)
            if (cap_ws[cap_base+i] !== exp_ws[i] || cap_sd[cap_base+i] !== exp_sd[i]) begin
                if (first < 0) first = i;
                bad++;
            end
        check(bad == 0, req, $sformatf("mismatched bits (first at %0d)", first), bad, 0);
    endtask

    task automatic check_idle(input string req);
        check(!bit_clk && !word_sel && !ser_data && !fifo_rd_en, req, "outputs idle",
              {bit_clk, word_sel, ser_data, fifo_rd_en}, 0);
    endtask

    // R1: reset and idle
    task automatic t_reset();
        int n0 = cap_n;
        check_idle("R1");
        repeat (50) @(negedge clk);
        check_idle("R1");
        check(cap_n == n0, "R1", "bit clock edges while idle", cap_n - n0, 0);
    endtask

    // R3 R4 R5 R6 R7 R8: basic 16-bit stereo, data runs out
    task automatic t_basic();
        int rd0 = f_rd;
        push(32'hDEAD_1234); push(32'hBEEF_8001);
        push(32'hFFFF_A5C3); push(32'h0000_7FFE);
        begin_run(8'd2, 6'd16);
        add_frame(16, 0, 0);
        add_frame(16, 32'h1234, 32'h8001);
        add_frame(16, 32'hA5C3, 32'h7FFE);
        add_frame(16, 0, 0);
        wait_bits(16);
        check(f_rd == rd0, "R5", "pops during zero frame", f_rd - rd0, 0);
        wait_bits(3*32 + 5);
        check(period == 8, "R2", "bit period ratio 2", period, 8);
        check(high_len == 4, "R2", "high time ratio 2", high_len, 4);
        check(f_rd - rd0 == 4, "R6", "words popped", f_rd - rd0, 4);
        stop_run();
        compare_run("R3_R4_R7_R8");
        check_idle("R8");
    endtask

    // R2 R3: clock ratio and resolution clamp
    task automatic t_clock(input logic [7:0] rt, input logic [5:0] rs, input int w);
        int rd0 = f_rd;
        push(32'hC35A_96F1); push(32'h8421_7BDE);
        begin_run(rt, rs);
        add_frame(w, 0, 0);
        add_frame(w, 32'hC35A_96F1, 32'h8421_7BDE);
        wait_bits(2*w + 3);
        check(period == 2*(rt+2), "R2", "bit period", period, 2*(rt+2));
        check(high_len == rt+2, "R2", "high time", high_len, rt+2);
        stop_run();
        compare_run("R3");
        check(f_rd - rd0 == 2, "R6", "words popped", f_rd - rd0, 2);
    endtask

    // R7: only a left word is queued
    task automatic t_empty_slot();
        int rd0 = f_rd;
        push(32'h0000_00B7);
        begin_run(8'd1, 6'd8);
        add_frame(8, 0, 0);
        add_frame(8, 32'hB7, 0);
        wait_bits(16 + 3);
        stop_run();
        compare_run("R7");
        check(f_rd - rd0 == 1, "R7", "words popped", f_rd - rd0, 1);
    endtask

    // R9: resolution and ratio changed mid-frame
    task automatic t_reconfig();
        push(32'h0000_0069); push(32'h0000_00F0);
        push(32'h0000_000A); push(32'h0000_0005);
        begin_run(8'd1, 6'd8);
        add_frame(8, 0, 0);
        add_frame(8, 32'h69, 32'hF0);
        add_frame(4, 32'hA, 32'h5);
        wait_bits(16 + 3);
        @(negedge clk);
        resolution = 6'd4;
        ratio = 8'd3;
        wait_bits(32 + 6);
        check(period == 10, "R9", "bit period after change", period, 10);
        stop_run();
        compare_run("R9");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_clock(8'd0, 6'd32, 32);
        t_clock(8'd5, 6'd8, 8);
        t_clock(8'd0, 6'd1, 2);
        t_clock(8'd0, 6'd63, 32);
        t_empty_slot();
        t_reconfig();
        check_idle("R8");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule